// File: doc/BRIEF.md
# Gated Serial Mirror-Group Detector

This block accepts a serial bit stream one bit per clock, but keeps only the bits that arrive while the qualifier input is high. Qualified bits do not have to arrive in consecutive clocks. Idle clocks can sit between them and do not disturb the group being built. The block sorts the qualified bits into groups of four that do not overlap. When a group is complete, the block decides whether the group reads the same forwards and backwards.

Each completed group produces a one-clock strobe on the group-done output. If the group is symmetric, a one-clock pulse also appears on the match output in the same clock. Once a group has been judged, the next judgement uses four new qualified bits only. Bits from an earlier group are never reused, so sliding windows are not detected.

Top module: `mirror_group_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are 0 after that edge. The partial group is discarded.
- R2: In a clock where `en_i` is 0, the value on `d_i` is ignored. That clock neither adds a bit nor moves the group position, and `v_o` is 0 in the following clock.
- R3: `v_o` is 1 in exactly the clock that follows the edge where the fourth qualified bit of a group is captured. This holds whether or not the group is symmetric.
- R4: In that same clock, `p_o` is 1 only if the first qualified bit of the group equals the fourth and the second equals the third. Otherwise `p_o` is 0.
- R5: `v_o` and `p_o` are single-clock pulses. Neither stays high in the clock after it was high.
- R6: Groups do not overlap. After a completion, no further completion occurs until four more qualified bits have been captured. The fifth, sixth and seventh qualified bits produce no strobe.
- R7: `p_o` is never 1 in a clock where `v_o` is 0.
- R8: If reset occurs in the middle of a group, the bits captured before it are dropped. After release, the next strobe comes on the fourth qualified bit that follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| d_i | input | 1 | Serial data bit |
| en_i | input | 1 | Qualifier; `d_i` is taken only when this is 1 |
| v_o | output | 1 | Group-complete strobe, one clock |
| p_o | output | 1 | Symmetric-group pulse, one clock, only with `v_o` |

## Verification
The hardest case to reach from the ports is a group whose four qualified bits are spread across many idle clocks, with random data on `d_i` during those idle clocks. Such a group must still be judged only on its four qualified bits and must finish at the correct boundary. Random stimulus reaches this case by dropping the qualifier in about 40 % of clocks while `d_i` keeps toggling. A directed phase walks all sixteen group values, each with idle gaps of varying length. A separate directed case resets the block after two qualified bits and checks that the following group still completes on exactly its fourth new bit.

// File: rtl/mirror_pkg.sv
// Shared definitions for the mirror-group detector.
// Assumes: a group has at least two bits.
package mirror_pkg;
    parameter int MIRROR_GROUP_BITS = 4;

    // Registered verdict that the top module drives onto its outputs
    typedef struct packed {
        logic done;
        logic match;
    } mirror_verdict_t;
endpackage

// File: rtl/mirror_shifter.sv
// Serial-in shift register that advances only on qualified clocks.
// The oldest bit ends up in the MSB. next_o shows the contents as they
// would be after the current bit is shifted in, so a completed group can
// be judged in the same clock that its last bit arrives.
// Assumes: WIDTH >= 2.
module mirror_shifter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] next_o
);
    logic [WIDTH-1:0] store_q;

    // Contents after a shift at this edge
    always_comb begin
        next_o = {store_q[WIDTH-2:0], bit_i};
    end

    // Hold the window; shift only on qualified bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (shift_i) begin
            store_q <= next_o;
        end
    end
endmodule

// File: rtl/mirror_position.sv
// Counts qualified bits inside the current group and wraps at the group
// size. last_o marks the qualified bit that closes a group.
// Assumes: GROUP >= 2.
module mirror_position #(
    parameter int GROUP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic last_o
);
    localparam int POS_W = (GROUP > 2) ? $clog2(GROUP) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(GROUP - 1);

    logic [POS_W-1:0] pos_q;

    // Closing bit: a qualified bit arriving at the final position
    always_comb begin
        last_o = step_i && (pos_q == POS_LAST);
    end

    // Advance on each qualified bit, wrap after the closing bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (last_o) begin
            pos_q <= '0;
        end else if (step_i) begin
            pos_q <= pos_q + POS_W'(1);
        end
    end
endmodule

// File: rtl/mirror_compare.sv
// Combinational symmetry test: bit k must equal bit WIDTH-1-k for every
// pair. A middle bit, present when WIDTH is odd, is left unchecked.
// Assumes: WIDTH >= 2.
module mirror_compare #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             sym_o
);
    localparam int PAIRS = WIDTH / 2;

    logic [PAIRS-1:0] pair_eq;

    genvar k;
    generate
        for (k = 0; k < PAIRS; k++) begin : g_pair
            // One equality per mirrored pair
            assign pair_eq[k] = (word_i[k] == word_i[WIDTH-1-k]);
        end
    endgenerate

    // All pairs must agree
    always_comb begin
        sym_o = &pair_eq;
    end
endmodule

// File: rtl/mirror_group_detector.sv
// Gated serial detector for symmetric, non-overlapping groups of bits.
// Qualified bits (en_i = 1) fill a group. The clock after the closing
// bit, v_o pulses, and p_o pulses together with it if the group is
// symmetric. Reset is synchronous and active low.
// Assumes: GROUP_BITS >= 2; inputs are synchronous to clk.
module mirror_group_detector #(
    parameter int GROUP_BITS = mirror_pkg::MIRROR_GROUP_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    input  logic en_i,
    output logic v_o,
    output logic p_o
);
    import mirror_pkg::*;

    logic [GROUP_BITS-1:0] window_next;
    logic                  closing;
    logic                  symmetric;
    mirror_verdict_t       verdict_q;

    mirror_shifter #(.WIDTH(GROUP_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (en_i),
        .bit_i   (d_i),
        .next_o  (window_next)
    );

    mirror_position #(.GROUP(GROUP_BITS)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (en_i),
        .last_o (closing)
    );

    mirror_compare #(.WIDTH(GROUP_BITS)) u_cmp (
        .word_i (window_next),
        .sym_o  (symmetric)
    );

    // Register the verdict for one clock after a group closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q.done  <= closing;
            verdict_q.match <= closing && symmetric;
        end
    end

    // Drive the outputs from the registered verdict
    always_comb begin
        v_o = verdict_q.done;
        p_o = verdict_q.match;
    end
endmodule

// File: rtl/mirror_group_detector_chk.sv
// Port-level properties for the mirror-group detector, bound to the top.
module mirror_group_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic v_o,
    input logic p_o
);
    // R1: reset clears both outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!v_o && !p_o));

    // R2: an idle clock cannot close a group
    a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !v_o);

    // R5: the strobe lasts one clock
    a_r5_v_single: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |=> !v_o);

    // R5: the match pulse lasts one clock
    a_r5_p_single: assert property (@(posedge clk) disable iff (!rst_n)
        p_o |=> !p_o);

    // R7: a match only comes with a completed group
    a_r7_match_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        p_o |-> v_o);
endmodule

bind mirror_group_detector mirror_group_detector_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .v_o   (v_o),
    .p_o   (p_o)
);

// File: tb/mirror_group_detector_tb.sv
`timescale 1ns/1ps
module mirror_group_detector_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d_i = 1'b0;
    logic en_i = 1'b0;
    logic v_o, p_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [3:0] m_bits = '0;
    int         m_pos = 0;
    logic       exp_v = 1'b0;
    logic       exp_p = 1'b0;
    logic       prev_v = 1'b0;

    always #2.5 clk = ~clk;

    mirror_group_detector u_dut (
        .clk (clk), .rst_n (rst_n), .d_i (d_i), .en_i (en_i),
        .v_o (v_o), .p_o (p_o)
    );

    function automatic logic is_mirror(input logic [3:0] w);
        return (w[3] == w[0]) && (w[2] == w[1]);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model, check at next negedge
    task automatic step(input logic en, input logic d);
        string vtag;
        en_i = en;
        d_i  = d;
        prev_v = exp_v;
        exp_v = 1'b0;
        exp_p = 1'b0;
        if (en) begin
            m_bits = {m_bits[2:0], d};
            if (m_pos == 3) begin
                exp_v = 1'b1;
                exp_p = is_mirror(m_bits);
                m_pos = 0;
            end else begin
                m_pos++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (exp_v)       vtag = "R3";
        else if (!en)    vtag = "R2";
        else if (prev_v) vtag = "R5";
        else             vtag = "R6";
        check(vtag, v_o, exp_v);
        check(exp_v ? "R4" : "R7", p_o, exp_p);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            en_i = 1'b1;
            d_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check("R1", v_o, 1'b0);
            check("R1", p_o, 1'b0);
        end
        m_bits = '0;
        m_pos = 0;
        exp_v = 1'b0;
        exp_p = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        do_reset(3);

        // Directed: every group value, with idle gaps of varying length
        for (int g = 0; g < 16; g++) begin
            for (int b = 3; b >= 0; b--) begin
                for (int gap = 0; gap < (g % 3); gap++) step(1'b0, ~g[b]);
                step(1'b1, g[b]);
            end
        end

        // Directed R6: seven qualified bits back to back, only one strobe
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
        step(1'b1, 1'b1);

        // Directed R8: reset mid-group, then a fresh mirrored group
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        do_reset(1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);   // R8: fourth new bit closes a mirrored group
        check("R8", v_o, 1'b1);
        check("R8", p_o, 1'b1);

        // Random: sparse qualifier, toggling data
        for (int i = 0; i < 3000; i++) begin
            logic en, d;
            en = ($urandom % 10) < 6;
            d  = $urandom % 2;
            step(en, d);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule